// File: doc/BRIEF.md
# Synchronous Slave-FIFO Bus Master

This block sits on the FPGA side of a synchronous slave-FIFO bus and acts as the master. The bus leads to an external USB bridge. The bridge holds four FIFO threads, and a 2-bit address selects one of them. The block turns a local request into a flag-qualified burst. A read request names a thread and a maximum word count. The block then pulls 16-bit words until that count is reached or the thread runs dry, and hands each word out with a valid pulse. A write request also names a thread and a count, with an optional packet-end marker. The block takes words from a local source until the count is reached or the thread fills up, and tells the source when each word has been consumed.

All bus controls are active-low and registered, and they change on the single interface clock. The data bus is split into an input, an output and a drive enable, so the pad ring can build the tri-state buffer. The master drives the bus only while it issues write strobes. It leaves at least one idle cycle whenever the bus changes direction. The partial (watermark) flag from the bridge is sampled and passed on to the local side.

Top module: `sfifo_master`

## Requirements
- R1: After reset, bus_cs_no, bus_oe_no, bus_rd_no, bus_wr_no and bus_pkt_no are all high, bus_data_oe_o is low, and busy_o and rd_valid_o are low.
- R2: A write burst holds bus_addr_o at the requested thread while bus_cs_no is low and presents wr_data_i on bus_data_o with bus_wr_no low. A word counts as written at each clock edge where bus_wr_no is low and bus_full_ni is high. wr_take_o is high in exactly those cycles, and the burst ends after wr_len_i accepted words.
- R3: When bus_full_ni is sampled low while bus_wr_no is low, that word is not taken (wr_take_o low), bus_wr_no is high in the next cycle, and the burst ends.
- R4: When wr_pkt_i is set with the request, bus_pkt_no is low together with bus_wr_no for the last word of the requested length only. It is never low without bus_wr_no low.
- R5: A read burst drives bus_cs_no, bus_oe_no and bus_rd_no low in the same cycle, which is the first cycle after rd_go_i is sampled.
- R6: A read word counts as accepted at each edge where bus_rd_no is low and bus_empty_ni is high. The bus data is captured 2 clock edges later (RD_LAT=2), and rd_valid_o is high with rd_data_o for the one cycle after that capture edge. Words arrive in FIFO order.
- R7: When bus_empty_ni is sampled low while bus_rd_no is low, bus_rd_no is high in the next cycle and the read burst ends early. A read of len words therefore issues len strobes if enough data is present, and otherwise one strobe more than the number of words read.
- R8: bus_data_oe_o is never high while bus_oe_no is low. bus_oe_no stays low until the last accepted read word has been captured.
- R9: The direction of the data bus never changes from one cycle to the next. A cycle with bus_oe_no low is never directly followed by a cycle with bus_data_oe_o high, or the other way round. After each burst, bus_cs_no stays high for at least one cycle.
- R10: A request with a length of 0 is ignored: busy_o stays low and bus_cs_no stays high.
- R11: If rd_go_i and wr_go_i are sampled high together while idle, only the read is performed.
- R12: wm_o equals bus_partial_ni as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_go_i | input | 1 | Start a read burst (sampled while idle) |
| rd_addr_i | input | 2 | Thread for the read |
| rd_len_i | input | 8 | Maximum words to read |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | 16 | Read word |
| wr_go_i | input | 1 | Start a write burst (sampled while idle) |
| wr_addr_i | input | 2 | Thread for the write |
| wr_len_i | input | 8 | Words to write |
| wr_pkt_i | input | 1 | Mark the last word with packet end |
| wr_data_i | input | 16 | Current word from the local source |
| wr_take_o | output | 1 | Current source word consumed at this edge |
| busy_o | output | 1 | A burst or turnaround is in progress |
| wm_o | output | 1 | Registered partial flag |
| bus_addr_o | output | 2 | Thread address |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_oe_no | output | 1 | Output enable, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_pkt_no | output | 1 | Packet end, active low |
| bus_empty_ni | input | 1 | Data available (low when empty) |
| bus_full_ni | input | 1 | Space available (low when full) |
| bus_partial_ni | input | 1 | Watermark flag |
| bus_data_i | input | 16 | Data from the bus |
| bus_data_o | output | 16 | Data to the bus |
| bus_data_oe_o | output | 1 | Drive enable for bus_data_o |

## Verification
A bad burst counter shows up within one burst. The bridge would then hold a different number of words than requested, or the bench would count an extra or a missing strobe against the flag-derived expectation. A stuck or wrong state shows up within a cycle or two as a direction overlap between output enable and data drive, an address change under chip select, or a packet end without a write strobe. A wrong read pipeline depth releases output enable before the last word returns, so the data captured after that reads as the idle bus value. The bench checks read latency to the exact cycle.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_DRAIN,
    ST_WR,
    ST_TURN
  } sfm_state_e;
endpackage

// File: rtl/sfm_burst_cnt.sv
module sfm_burst_cnt #(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [LW-1:0] len_i,
  output logic          last_o,
  output logic          next_last_o
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + LW'(1);
  end

  assign last_o      = (cnt_q == len_i - LW'(1));
  assign next_last_o = (cnt_q + LW'(1) == len_i - LW'(1));

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q < len_i)); // R2
endmodule

// File: rtl/sfm_rd_pipe.sv
module sfm_rd_pipe #(
  parameter int DW     = 16,
  parameter int RD_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic [RD_LAT-1:0] p_q;

  generate
    if (RD_LAT == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= acc_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= {p_q[RD_LAT-2:0], acc_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= p_q[RD_LAT-1];
      if (p_q[RD_LAT-1]) data_o <= data_i;
    end
  end

  assign busy_o = |p_q;
endmodule

// File: rtl/sfifo_master.sv
module sfifo_master
  import sfm_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 2,
  parameter int LW     = 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_go_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [LW-1:0] rd_len_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_go_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [LW-1:0] wr_len_i,
  input  logic          wr_pkt_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_take_o,
  output logic          busy_o,
  output logic          wm_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_cs_no,
  output logic          bus_oe_no,
  output logic          bus_rd_no,
  output logic          bus_wr_no,
  output logic          bus_pkt_no,
  input  logic          bus_empty_ni,
  input  logic          bus_full_ni,
  input  logic          bus_partial_ni,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o
);
  sfm_state_e    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] len_q, len_d;
  logic          pkt_q, pkt_d;
  logic          cs_q, oe_q, rd_q, wr_q, pe_q, doe_q, wm_q;
  logic          cs_d, oe_d, rd_d, wr_d, pe_d, doe_d;
  logic          clr, rd_acc, wr_acc, cnt_last, cnt_next_last, pipe_busy;

  assign rd_acc = (st_q == ST_RD) && !rd_q && bus_empty_ni;
  assign wr_acc = (st_q == ST_WR) && bus_full_ni;

  sfm_burst_cnt #(.LW(LW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .inc_i       (rd_acc || wr_acc),
    .len_i       (len_q),
    .last_o      (cnt_last),
    .next_last_o (cnt_next_last)
  );

  sfm_rd_pipe #(.DW(DW), .RD_LAT(RD_LAT)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (rd_acc),
    .data_i  (bus_data_i),
    .busy_o  (pipe_busy),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  always_comb begin
    st_d = st_q;  addr_d = addr_q; len_d = len_q; pkt_d = pkt_q;
    cs_d = cs_q;  oe_d = oe_q;     rd_d = rd_q;   wr_d = wr_q;
    pe_d = pe_q;  doe_d = doe_q;   clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        // read wins a tie
        if (rd_go_i && rd_len_i != '0) begin
          st_d = ST_RD; addr_d = rd_addr_i; len_d = rd_len_i; clr = 1'b1;
          cs_d = 1'b0;  oe_d = 1'b0;        rd_d = 1'b0;
        end else if (wr_go_i && wr_len_i != '0) begin
          st_d = ST_WR; addr_d = wr_addr_i; len_d = wr_len_i; pkt_d = wr_pkt_i;
          clr = 1'b1;   cs_d = 1'b0;        wr_d = 1'b0;     doe_d = 1'b1;
          pe_d = !(wr_pkt_i && wr_len_i == LW'(1));
        end
      end
      ST_RD: begin
        if (!bus_empty_ni || (rd_acc && cnt_last)) begin
          st_d = ST_DRAIN; rd_d = 1'b1;
        end
      end
      ST_DRAIN: begin
        // hold OE until every accepted word is captured
        if (!pipe_busy) begin
          st_d = ST_TURN; cs_d = 1'b1; oe_d = 1'b1;
        end
      end
      ST_WR: begin
        if (!bus_full_ni || cnt_last) begin
          st_d = ST_TURN; cs_d = 1'b1; wr_d = 1'b1; pe_d = 1'b1; doe_d = 1'b0;
        end else begin
          pe_d = !(pkt_q && cnt_next_last);
        end
      end
      ST_TURN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE; addr_q <= '0;   len_q <= '0;   pkt_q <= 1'b0;
      cs_q  <= 1'b1;    oe_q   <= 1'b1; rd_q  <= 1'b1; wr_q  <= 1'b1;
      pe_q  <= 1'b1;    doe_q  <= 1'b0; wm_q  <= 1'b0;
    end else begin
      st_q  <= st_d;    addr_q <= addr_d; len_q <= len_d; pkt_q <= pkt_d;
      cs_q  <= cs_d;    oe_q   <= oe_d;   rd_q  <= rd_d;  wr_q  <= wr_d;
      pe_q  <= pe_d;    doe_q  <= doe_d;  wm_q  <= bus_partial_ni;
    end
  end

  assign bus_addr_o    = addr_q;
  assign bus_cs_no     = cs_q;
  assign bus_oe_no     = oe_q;
  assign bus_rd_no     = rd_q;
  assign bus_wr_no     = wr_q;
  assign bus_pkt_no    = pe_q;
  assign bus_data_oe_o = doe_q;
  assign bus_data_o    = wr_data_i;
  assign wr_take_o     = wr_acc;
  assign busy_o        = (st_q != ST_IDLE);
  assign wm_o          = wm_q;

  AST_BUS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> bus_oe_no); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && $past(!bus_cs_no)) |-> $stable(bus_addr_o)); // R2
  AST_RD_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_no && !bus_empty_ni) |=> bus_rd_no); // R7
  AST_WR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_no && !bus_full_ni) |=> bus_wr_no); // R3
  AST_PKT_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_pkt_no |-> !bus_wr_no); // R4
  AST_TURN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_cs_no) |=> bus_cs_no); // R9
  AST_RD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_rd_no) |-> (!bus_oe_no && !bus_cs_no)); // R5
endmodule

// File: tb/sim_sfifo_master.sv
module sim_sfifo_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        rd_go = 0, wr_go = 0, wr_pkt = 0;
  logic [1:0]  rd_addr = 0, wr_addr = 0;
  logic [7:0]  rd_len = 0, wr_len = 0;
  logic        rd_valid, wr_take, busy, wm;
  logic [15:0] rd_data, wr_data, bus_dout, bus_din, drv, s1;
  logic [1:0]  baddr;
  logic        cs_n, oe_n, rd_n, wr_n, pk_n, doe, empty_n, full_n, part_n;

  sfifo_master u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_go_i(rd_go), .rd_addr_i(rd_addr), .rd_len_i(rd_len),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .wr_go_i(wr_go), .wr_addr_i(wr_addr), .wr_len_i(wr_len), .wr_pkt_i(wr_pkt),
    .wr_data_i(wr_data), .wr_take_o(wr_take), .busy_o(busy), .wm_o(wm),
    .bus_addr_o(baddr), .bus_cs_no(cs_n), .bus_oe_no(oe_n), .bus_rd_no(rd_n),
    .bus_wr_no(wr_n), .bus_pkt_no(pk_n), .bus_empty_ni(empty_n),
    .bus_full_ni(full_n), .bus_partial_ni(part_n), .bus_data_i(bus_din),
    .bus_data_o(bus_dout), .bus_data_oe_o(doe)
  );

  // bridge model: four threads, depth 8, watermark 4, read latency 2
  logic [15:0] mem [4][32];
  logic        pe_log [4][32];
  int hd [4], tl [4];
  int occ, ng, src, rstb, wstb;
  logic [15:0] got [32];
  logic m_clr = 0, m_load = 0;
  int   m_t = 0, m_n = 0;

  always_comb begin
    occ     = tl[baddr] - hd[baddr];
    empty_n = (occ != 0);
    full_n  = (occ < 8);
    part_n  = (occ >= 4);
  end
  assign bus_din = oe_n ? 16'hFFFF : drv;
  assign wr_data = 16'hA000 + src[15:0];

  always @(posedge clk) begin
    if (m_clr) begin
      for (int t = 0; t < 4; t++) begin hd[t] <= 0; tl[t] <= 0; end
      ng <= 0; src <= 0; rstb <= 0; wstb <= 0;
    end else begin
      if (m_load) begin
        for (int i = 0; i < m_n; i++)
          mem[m_t][tl[m_t]+i] <= 16'hC000 | 16'(m_t << 8) | 16'(i);
        tl[m_t] <= tl[m_t] + m_n;
      end
      if (!cs_n && !rd_n) begin
        rstb <= rstb + 1;
        if (tl[baddr] != hd[baddr]) begin
          s1 <= mem[baddr][hd[baddr]];
          hd[baddr] <= hd[baddr] + 1;
        end
      end
      if (!cs_n && !wr_n) begin
        wstb <= wstb + 1;
        if (tl[baddr] - hd[baddr] < 8) begin
          mem[baddr][tl[baddr]]    <= bus_dout;
          pe_log[baddr][tl[baddr]] <= !pk_n;
          tl[baddr] <= tl[baddr] + 1;
        end
      end
      if (rd_valid) begin got[ng] <= rd_data; ng <= ng + 1; end
      if (wr_take) src <= src + 1;
    end
    drv <= s1;
  end

  // port monitors
  int dir_bad = 0, addr_bad = 0, pe_bad = 0, wm_bad = 0;
  logic p_oe_low = 0, p_doe = 0, p_cs_low = 0, p_pn = 0, mon_on = 0;
  logic [1:0] p_addr = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (doe && !oe_n) dir_bad++;
      if ((p_oe_low && doe) || (p_doe && !oe_n)) dir_bad++;
      if (p_cs_low && !cs_n && baddr != p_addr) addr_bad++;
      if (!pk_n && wr_n) pe_bad++;
      if (wm !== p_pn) wm_bad++;
    end
    p_oe_low = !oe_n; p_doe = doe; p_cs_low = !cs_n; p_addr = baddr; p_pn = part_n;
    if (rst_n) mon_on = 1;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    @(negedge clk) m_clr = 1;
    @(negedge clk) m_clr = 0;
  endtask

  task automatic m_preload(input int t, input int n);
    if (n > 0) begin
      @(negedge clk) begin m_t = t; m_n = n; m_load = 1; end
      @(negedge clk) m_load = 0;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_write(input int t, input int len, input bit pkt, input int pre);
    int exp, bad, pbad;
    m_clear();
    m_preload(t, pre);
    @(negedge clk) begin wr_addr = 2'(t); wr_len = 8'(len); wr_pkt = pkt; wr_go = 1; end
    @(negedge clk) wr_go = 0;
    wait_idle();
    exp = (len < 8 - pre) ? len : 8 - pre;
    chk(tl[t] - pre == exp, "R2 words stored", tl[t] - pre, exp);
    bad = 0; pbad = 0;
    for (int i = 0; i < exp; i++) begin
      if (mem[t][pre+i] != 16'hA000 + 16'(i)) bad++;
      if (pe_log[t][pre+i] != (pkt && exp == len && i == exp - 1)) pbad++;
    end
    chk(bad == 0, "R2 write data order", bad, 0);
    chk(pbad == 0, "R4 packet end placement", pbad, 0);
    chk(src == exp, "R3 source words consumed", src, exp);
    chk(wstb == exp + ((exp < len) ? 1 : 0), "R3 write strobe count", wstb,
        exp + ((exp < len) ? 1 : 0));
  endtask

  task automatic t_read(input int t, input int pre, input int len);
    int n, bad, es;
    m_clear();
    m_preload(t, pre);
    @(negedge clk) begin rd_addr = 2'(t); rd_len = 8'(len); rd_go = 1; end
    @(negedge clk) rd_go = 0;
    chk(!cs_n && !oe_n && !rd_n, "R5 cs oe rd low together", {cs_n, oe_n, rd_n}, 0);
    if (pre > 0) begin
      @(negedge clk);
      @(negedge clk);
      chk(!rd_valid, "R6 no data before latency", rd_valid, 0);
      @(negedge clk);
      chk(rd_valid && rd_data == (16'hC000 | 16'(t << 8)), "R6 first word timing",
          rd_data, 16'hC000 | 16'(t << 8));
    end
    wait_idle();
    n = (pre < len) ? pre : len;
    chk(ng == n, "R6 words read", ng, n);
    bad = 0;
    for (int i = 0; i < n; i++)
      if (got[i] != (16'hC000 | 16'(t << 8) | 16'(i))) bad++;
    chk(bad == 0, "R8 read data intact", bad, 0);
    es = n + ((pre < len) ? 1 : 0);
    chk(rstb == es, "R7 read strobe count", rstb, es);
  endtask

  task automatic t_zero();
    int seen = 0;
    m_clear();
    @(negedge clk) begin rd_len = 0; wr_len = 0; rd_go = 1; wr_go = 1; end
    @(negedge clk) begin rd_go = 0; wr_go = 0; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy || !cs_n) seen++;
    end
    chk(seen == 0, "R10 zero length ignored", seen, 0);
  endtask

  task automatic t_both();
    m_clear();
    m_preload(3, 3);
    @(negedge clk) begin
      rd_addr = 3; rd_len = 2; wr_addr = 1; wr_len = 2; wr_pkt = 0;
      rd_go = 1; wr_go = 1;
    end
    @(negedge clk) begin rd_go = 0; wr_go = 0; end
    wait_idle();
    chk(ng == 2 && wstb == 0, "R11 read wins tie", {ng[7:0], wstb[7:0]}, 16'h0200);
  endtask

  initial begin
    m_clr = 1;
    repeat (3) @(negedge clk);
    chk(cs_n && oe_n && rd_n && wr_n && pk_n && !doe && !busy && !rd_valid,
        "R1 reset levels", {cs_n, oe_n, rd_n, wr_n, pk_n, doe, busy, rd_valid}, 8'hF8);
    rst_n = 1;
    @(negedge clk) m_clr = 0;
    t_write(1, 5, 0, 0);
    t_write(2, 3, 1, 0);
    t_write(0, 5, 1, 6);
    t_write(3, 1, 1, 0);
    t_read(1, 5, 10);
    t_read(3, 6, 2);
    t_read(2, 8, 8);
    t_read(0, 0, 3);
    t_zero();
    t_both();
    chk(dir_bad == 0, "R9 bus direction turnaround", dir_bad, 0);
    chk(addr_bad == 0, "R2 address held", addr_bad, 0);
    chk(pe_bad == 0, "R4 packet end qualified", pe_bad, 0);
    chk(wm_bad == 0, "R12 watermark follows flag", wm_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule